// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is a synchronous supervisor that drives a processor reset line. Three conditions can pull the reset low. The first is a low-supply flag, already digitized, that comes from an external comparator. The second is a watchdog that ran out because no strobe activity arrived in time. The third is a push-button that has been held long enough to count as deliberate. All three sources share a single pulse stretcher, so every release from reset is followed by a guaranteed minimum hold time.

All time intervals are counted in ticks from an internal prescaler. With the default parameters, one tick is 1 ms at a 100 MHz clock. The watchdog period, the stretch length and the push-button qualification time are parameters, and a simulation can shorten them. A level input switches the watchdog on or off. A status flag reports whether the watchdog has expired since it was last serviced. The module's own power-on reset asserts the reset outputs at once, and they release only after a full stretch interval.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_low_i` is high (1 = supply low), `rst_n_o` is held at 0 for as long as the flag stays high.
- R2: After the last hold or trigger condition clears, `rst_n_o` stays 0 for at least STRETCH_TICKS ticks and at most STRETCH_TICKS+1 ticks, plus the synchronizer latency. It then returns to 1, and the release happens only on a tick boundary.
- R3: When `wd_enable_i` is 1 and `wd_strobe_i` shows no edge for WDOG_TICKS ticks, the watchdog expires and `rst_n_o` goes to 0 on the following cycle for one full stretch interval.
- R4: If the watchdog is still not serviced, it expires again once every WDOG_TICKS ticks, and each expiry produces a new reset pulse.
- R5: A low level on `pb_n_i` (0 = pressed) that lasts fewer than PB_TICKS-1 ticks has no effect on `rst_n_o`.
- R6: A low level on `pb_n_i` that lasts PB_TICKS+1 ticks or more is accepted. `rst_n_o` then stays 0 for as long as the button is held, and for one stretch interval counted from the moment of release.
- R7: A rising edge and a falling edge on `wd_strobe_i` both service the watchdog and restart its period.
- R8: `wd_ok_o` drops to 0 in the same cycle that the watchdog expires. It returns to 1 on any strobe edge, and also while `supply_low_i` is high.
- R9: While `wd_enable_i` is 0, the watchdog never expires and its period counter is held at zero.
- R10: `rst_o` is always the logical inverse of `rst_n_o`.
- R11: While `por_n` is 0, `rst_n_o` is 0 and `wd_ok_o` is 1. After `por_n` returns to 1, a full stretch interval passes before `rst_n_o` returns to 1.
- R12: While `supply_low_i` is high, the watchdog period counter is held at zero, so a full period is restarted once the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of the block itself |
| supply_low_i | input | 1 | Digitized low-supply flag, active high, asynchronous |
| wd_strobe_i | input | 1 | Watchdog service strobe; any edge services it |
| wd_enable_i | input | 1 | 1 enables the watchdog, 0 disables it |
| pb_n_i | input | 1 | Push-button, active low, asynchronous |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high (inverse of rst_n_o) |
| wd_ok_o | output | 1 | Watchdog status: 0 after an expiry, 1 after service |

## Verification
The bench checks the stretch at both ends of its window: reset must still be asserted shortly before the minimum hold ends and released just after the maximum. A stretcher that is too short, or one that never restarts, fails one of those two samples. A push-button pulse that is slightly too short is sent to catch a qualifier that accepts too early, and the hold that follows a long press is timed from the release so that a stretcher triggered on the press is exposed. The watchdog is fed on both edges, and then left unserviced across two periods; this catches a design that services on only one edge or fires only once. A low-supply window is placed where a counter that is not cleared during low supply would fire a stray reset soon after the flag drops.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Number of synchronizer flops for every asynchronous input.
    localparam int unsigned SYNC_STAGES = 2;

    // Width of a counter that has to hold the value 'limit'.
    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned   W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    import sup_pkg::*;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [SYNC_STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[SYNC_STAGES-2:0], d_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {SYNC_STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign q_o[b] = chain_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/sup_tick.sv
module sup_tick #(
    parameter int unsigned CLKS_PER_TICK = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    import sup_pkg::*;

    if (CLKS_PER_TICK <= 1) begin : g_every
        logic tick_d, tick_q;
        always_comb tick_d = 1'b1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= tick_d;
        end
        assign tick_o = tick_q;
    end else begin : g_div
        localparam int unsigned W = cnt_bits(CLKS_PER_TICK - 1);
        localparam logic [W-1:0] LAST = W'(CLKS_PER_TICK - 1);

        typedef struct packed {
            logic [W-1:0] cnt;
            logic         tick;
        } tick_st_t;

        tick_st_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            st_d.tick = 1'b0;
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign tick_o = st_q.tick;
    end

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
    parameter int unsigned WDOG_TICKS = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic strobe_i,
    input  logic enable_i,
    input  logic low_i,
    output logic expire_o,
    output logic ok_o
);
    import sup_pkg::*;

    localparam int unsigned W = cnt_bits(WDOG_TICKS);
    localparam logic [W-1:0] LAST = W'(WDOG_TICKS - 1);

    typedef struct packed {
        logic         prev;
        logic [W-1:0] cnt;
        logic         expire;
        logic         ok;
    } wd_st_t;

    wd_st_t st_d, st_q;
    logic   svc;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = strobe_i;
        st_d.expire = 1'b0;
        svc         = strobe_i ^ st_q.prev;

        if (low_i || !enable_i) begin
            st_d.cnt = '0;
        end else if (svc) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt    = '0;
                st_d.expire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (svc || low_i)       st_d.ok = 1'b1;
        else if (st_d.expire)   st_d.ok = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b0, cnt: '0, expire: 1'b0, ok: 1'b1};
        else        st_q <= st_d;
    end

    assign expire_o = st_q.expire;
    assign ok_o     = st_q.ok;

endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int unsigned PB_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pb_low_i,
    output logic hold_o
);
    import sup_pkg::*;

    // One tick more than the nominal time, so a partial first tick
    // never shortens the qualification.
    localparam int unsigned THR = PB_TICKS + 1;
    localparam int unsigned W   = cnt_bits(THR);
    localparam logic [W-1:0] THR_V = W'(THR);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         hold;
    } db_st_t;

    db_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pb_low_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != THR_V)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.hold = pb_low_i && (st_d.cnt == THR_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
    parameter int unsigned STRETCH_TICKS = 140
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic trig_i,
    output logic rst_n_o
);
    import sup_pkg::*;

    localparam int unsigned LOAD = STRETCH_TICKS + 1;
    localparam int unsigned W    = cnt_bits(LOAD);
    localparam logic [W-1:0] LOAD_V = W'(LOAD);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         active;
    } str_st_t;

    str_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i || trig_i) begin
            st_d.cnt = LOAD_V;
        end else if (tick_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.active = hold_i || trig_i || (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: LOAD_V, active: 1'b1};
        else        st_q <= st_d;
    end

    assign rst_n_o = ~st_q.active;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned CLKS_PER_TICK = 100000,
    parameter int unsigned WDOG_TICKS    = 1600,
    parameter int unsigned STRETCH_TICKS = 140,
    parameter int unsigned PB_TICKS      = 40
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_low_i,
    input  logic wd_strobe_i,
    input  logic wd_enable_i,
    input  logic pb_n_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic wd_ok_o
);
    localparam int unsigned N_ASYNC = 4;
    // Idle levels: supply fine, strobe low, watchdog off, button released.
    localparam logic [N_ASYNC-1:0] ASYNC_IDLE = 4'b0001;

    logic [N_ASYNC-1:0] async_in, async_s;
    logic low_s, strobe_s, en_s, pb_n_s;
    logic tick;
    logic wd_expire;
    logic pb_hold;
    logic hold_any;

    assign async_in = {supply_low_i, wd_strobe_i, wd_enable_i, pb_n_i};

    sup_sync #(.W(N_ASYNC), .RST_VAL(ASYNC_IDLE)) sync_i (
        .clk   (clk),
        .rst_n (por_n),
        .d_i   (async_in),
        .q_o   (async_s)
    );

    assign {low_s, strobe_s, en_s, pb_n_s} = async_s;

    sup_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) tick_i (
        .clk    (clk),
        .rst_n  (por_n),
        .tick_o (tick)
    );

    sup_watchdog #(.WDOG_TICKS(WDOG_TICKS)) wdog_i (
        .clk      (clk),
        .rst_n    (por_n),
        .tick_i   (tick),
        .strobe_i (strobe_s),
        .enable_i (en_s),
        .low_i    (low_s),
        .expire_o (wd_expire),
        .ok_o     (wd_ok_o)
    );

    sup_debounce #(.PB_TICKS(PB_TICKS)) pb_i (
        .clk      (clk),
        .rst_n    (por_n),
        .tick_i   (tick),
        .pb_low_i (~pb_n_s),
        .hold_o   (pb_hold)
    );

    assign hold_any = low_s | pb_hold;

    sup_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) str_i (
        .clk     (clk),
        .rst_n   (por_n),
        .tick_i  (tick),
        .hold_i  (hold_any),
        .trig_i  (wd_expire),
        .rst_n_o (rst_n_o)
    );

    assign rst_o = ~rst_n_o;

endmodule

// File: rtl/sup_checker.sv
module sup_checker (
    input logic clk,
    input logic por_n,
    input logic tick,
    input logic low_s,
    input logic en_s,
    input logic wd_expire,
    input logic pb_hold,
    input logic rst_n_o,
    input logic wd_ok_o
);

    // R1: synchronized low supply forces reset on the next cycle
    p_low_holds_r1: assert property (@(posedge clk) disable iff (!por_n)
        low_s |=> !rst_n_o);

    // R2: the release from reset happens only on a tick boundary
    p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_o) |-> $past(tick));

    // R3: an expiry is followed by an asserted reset
    p_expire_resets_r3: assert property (@(posedge clk) disable iff (!por_n)
        wd_expire |=> !rst_n_o);

    // R6: a qualified push-button keeps the reset asserted
    p_pb_holds_r6: assert property (@(posedge clk) disable iff (!por_n)
        pb_hold |=> !rst_n_o);

    // R8: the status flag falls only together with an expiry
    p_ok_falls_r8: assert property (@(posedge clk) disable iff (!por_n)
        $fell(wd_ok_o) |-> wd_expire);

    // R9: a disabled watchdog never expires
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!por_n)
        !en_s |=> !wd_expire);

    // R12: no expiry can follow a cycle of low supply
    p_low_clears_r12: assert property (@(posedge clk) disable iff (!por_n)
        low_s |=> !wd_expire);

endmodule

bind rst_supervisor sup_checker chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .tick      (tick),
    .low_s     (low_s),
    .en_s      (en_s),
    .wd_expire (wd_expire),
    .pb_hold   (pb_hold),
    .rst_n_o   (rst_n_o),
    .wd_ok_o   (wd_ok_o)
);

// File: tb/rst_supervisor_tb_top.sv
module rst_supervisor_tb_top;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic supply_low = 1'b0;
    logic strobe = 1'b0;
    logic wd_en = 1'b0;
    logic pb_n = 1'b1;
    logic rst_n, rst_p, wd_ok;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Tick = 4 clocks, watchdog 20 ticks, stretch 6 ticks, button 4 ticks.
    rst_supervisor #(
        .CLKS_PER_TICK (4),
        .WDOG_TICKS    (20),
        .STRETCH_TICKS (6),
        .PB_TICKS      (4)
    ) dut_i (
        .clk          (clk),
        .por_n        (por_n),
        .supply_low_i (supply_low),
        .wd_strobe_i  (strobe),
        .wd_enable_i  (wd_en),
        .pb_n_i       (pb_n),
        .rst_n_o      (rst_n),
        .rst_o        (rst_p),
        .wd_ok_o      (wd_ok)
    );

    typedef struct packed {
        logic        low;
        logic        strb;
        logic        en;
        logic        pb;
        logic [15:0] wait_c;
        logic        exp_rst_n;
        logic        exp_ok;
        logic [7:0]  req;
    } step_t;

    localparam int N_STEPS = 22;
    localparam step_t STEPS [N_STEPS] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'd10,  1'b0, 1'b1, 8'd1},  // R1 low asserts
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'd100, 1'b0, 1'b1, 8'd1},  // R1 still held
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd20,  1'b0, 1'b1, 8'd2},  // R2 min stretch
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd20,  1'b1, 1'b1, 8'd2},  // R2 released
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'd8,   1'b1, 1'b1, 8'd5},  // R5 short press
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd30,  1'b1, 1'b1, 8'd5},  // R5 ignored
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'd30,  1'b0, 1'b1, 8'd6},  // R6 accepted
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'd60,  1'b0, 1'b1, 8'd6},  // R6 held
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd20,  1'b0, 1'b1, 8'd6},  // R6 stretch from release
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd20,  1'b1, 1'b1, 8'd6},  // R6 released
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'd60,  1'b1, 1'b1, 8'd7},  // R7 rising edge
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'd60,  1'b1, 1'b1, 8'd7},  // R7 falling edge
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'd60,  1'b1, 1'b1, 8'd7},  // R7 rising again
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'd40,  1'b0, 1'b0, 8'd3},  // R3 expiry pulse
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'd40,  1'b1, 1'b0, 8'd4},  // R4 between pulses
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'd40,  1'b0, 1'b0, 8'd4},  // R4 second pulse
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'd40,  1'b1, 1'b1, 8'd8},  // R8 service restores
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd200, 1'b1, 1'b1, 8'd9},  // R9 disabled
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'd100, 1'b0, 1'b0, 8'd3},  // R3 after enable
        '{1'b1, 1'b0, 1'b1, 1'b1, 16'd40,  1'b0, 1'b1, 8'd8},  // R8 low sets ok
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'd40,  1'b1, 1'b1, 8'd12}, // R12 fresh period
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd10,  1'b1, 1'b1, 8'd9}   // R9 disable again
    };

    task automatic check(input string req, input logic act, input logic exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_outputs(input string req, input logic exp_rst_n,
                                 input logic exp_ok);
        check(req, rst_n, exp_rst_n, "rst_n_o");
        check("R10", rst_p, ~rst_n, "rst_o inverse");
        check(req, wd_ok, exp_ok, "wd_ok_o");
    endtask

    initial begin : watchdog_proc
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main_proc
        // R11: state during power-on reset
        wait_neg(3);
        check_outputs("R11", 1'b0, 1'b1);
        por_n = 1'b1;
        wait_neg(20);
        check("R11", rst_n, 1'b0, "rst_n_o before stretch ends");
        wait_neg(20);
        check("R11", rst_n, 1'b1, "rst_n_o after stretch");
        check("R10", rst_p, 1'b0, "rst_o after release");

        for (int s = 0; s < N_STEPS; s++) begin
            supply_low = STEPS[s].low;
            strobe     = STEPS[s].strb;
            wd_en      = STEPS[s].en;
            pb_n       = STEPS[s].pb;
            wait_neg(int'(STEPS[s].wait_c));
            check_outputs($sformatf("R%0d step %0d", STEPS[s].req, s),
                          STEPS[s].exp_rst_n, STEPS[s].exp_ok);
        end

        // R11: power-on reset in mid-run asserts at once, with wd_ok set
        @(negedge clk);
        por_n = 1'b0;
        #1;
        check("R11", rst_n, 1'b0, "rst_n_o on async por");
        check("R10", rst_p, 1'b1, "rst_o on async por");
        wait_neg(2);
        check("R11", wd_ok, 1'b1, "wd_ok_o during por");
        por_n = 1'b1;
        wait_neg(20);
        check("R11", rst_n, 1'b0, "rst_n_o stretch after mid-run por");
        wait_neg(20);
        check("R11", rst_n, 1'b1, "rst_n_o release after mid-run por");

        // R2: low pulse of a single clock still yields a full stretch
        supply_low = 1'b1;
        wait_neg(1);
        supply_low = 1'b0;
        wait_neg(22);
        check("R2", rst_n, 1'b0, "rst_n_o after brief low");
        wait_neg(20);
        check("R2", rst_n, 1'b1, "rst_n_o release after brief low");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule